// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Selector

This block computes the top-interrupt value for a virtual supervisor. It takes the virtual-supervisor pending and enable vectors and the hypervisor's virtual-interrupt control fields, and picks one winning interrupt. The result is a 32-bit word that carries the winner's 12-bit identity and its 8-bit priority. The block also drives a flag that says whether an interrupt is pending at virtual-supervisor level. Per-interrupt priority arrays are treated as all zero, so the reported priority comes only from the control fields.

The control fields are: a mode bit `ctlVti`, an injected identity `ctlIid`, an order bit `ctlDpr`, a priority-reporting bit `ctlIpriom` and a priority value `ctlIprio`.

With `ctlVti` low, the block does a fixed-order pick over the pending-and-enabled bits. With `ctlVti` high, two candidates compete: the supervisor external interrupt and an interrupt injected by the hypervisor, and `ctlDpr` decides which one wins. An all-zero control word gives plain fixed-order behaviour.

The result is registered by default (`REG_OUT=1`). It can be made purely combinational with `REG_OUT=0`.

Top module: `vs_top_intr_select`

## Requirements
- R1: With ctlVti=0, the winner is the highest-ranked bit of (vsPending & vsEnable). Rank order is bit 9 first, then bit 1, then bit 5, then every remaining bit in ascending index order.
- R2: With ctlVti=1, the external candidate (identity 9) exists only when bit 9 is set in both vsPending and vsEnable. No other pending bit is considered in this mode.
- R3: With ctlVti=1, the injected candidate has identity ctlIid and exists only when ctlIid is not 9. ctlIid=9 means nothing is injected.
- R4: With ctlVti=1 and both candidates present, ctlDpr=0 makes the injected candidate win and ctlDpr=1 makes the external candidate win.
- R5: With ctlIpriom=1 and the external interrupt winning, the priority is ctlIprio when ctlIid=9 and ctlIprio is nonzero. In every other case it is 255.
- R6: With ctlIpriom=1, ctlVti=1 and the injected candidate winning, the priority is:
  - ctlIprio when ctlIprio is nonzero;
  - 0 when ctlIprio is 0 and ctlDpr=0;
  - 255 when ctlIprio is 0 and ctlDpr=1.
- R7: With ctlIpriom=1, ctlVti=0 and a winner other than bit 9, the priority is 255.
- R8: With ctlIpriom=0, the priority is 1 whenever there is a winner.
- R9: The output word holds the identity in bits 27:16 and the priority in bits 7:0, with all other bits 0. The word is 0 when there is no winner. vsPendFlag is 1 exactly when the word is nonzero.
- R10: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. While rst is high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsPending | input | NUM_IRQ | Virtual-supervisor pending vector |
| vsEnable | input | NUM_IRQ | Virtual-supervisor enable vector |
| ctlVti | input | 1 | Selects two-candidate (injection) mode |
| ctlIid | input | 12 | Injected interrupt identity |
| ctlDpr | input | 1 | Candidate order: 1 means external wins |
| ctlIpriom | input | 1 | Report real priority (1) or constant 1 (0) |
| ctlIprio | input | 8 | Priority value from the control word |
| topWord | output | 32 | Packed identity and priority |
| vsPendFlag | output | 1 | Interrupt pending at virtual-supervisor level |

## Verification
With the default registered output, every result is due exactly one rising edge after the inputs that produce it. The bench drives a new input set on each falling edge. It keeps the expected word computed from the previous set and compares it at the following falling edge, after the capturing edge has passed. Reset cycles are checked against an expected zero. Directed vectors cover the rank order, both candidate orders and every branch of the priority rule. Pseudo-random vectors then cover the remaining combinations.

// File: rtl/vs_top_pkg.sv
package vs_top_pkg;
  localparam int ID_W     = 12;
  localparam int PRIO_W   = 8;
  localparam int WORD_W   = 32;
  localparam int EXT_ID   = 9;
  localparam int SOFT_ID  = 1;
  localparam int TIMER_ID = 5;
  localparam int ID_LSB   = 16;

  typedef enum logic [1:0] {
    PK_ZERO  = 2'd0,
    PK_ONE   = 2'd1,
    PK_IPRIO = 2'd2,
    PK_MAX   = 2'd3
  } prioKind_e;

  typedef struct packed {
    logic      selExt;
    logic      selInj;
    logic      selMajor;
    prioKind_e kind;
  } vsStrobe_t;
endpackage

// File: rtl/vs_major_enc.sv
module vs_major_enc #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] active,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  import vs_top_pkg::*;

  // Scan from the top down so the lowest plain bit is left standing,
  // then let the three ranked bits override in reverse rank order.
  always_comb begin
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (active[i] && i != EXT_ID && i != SOFT_ID && i != TIMER_ID)
        idx = IDX_W'(i);
    end
    if (active[TIMER_ID]) idx = IDX_W'(TIMER_ID);
    if (active[SOFT_ID])  idx = IDX_W'(SOFT_ID);
    if (active[EXT_ID])   idx = IDX_W'(EXT_ID);
    hit = |active;
  end
endmodule

// File: rtl/vs_top_ctrl.sv
module vs_top_ctrl
  import vs_top_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extPend,
  input  logic              extEn,
  input  logic              majorHit,
  input  logic [IDX_W-1:0]  majorIdx,
  input  logic              ctlVti,
  input  logic [ID_W-1:0]   ctlIid,
  input  logic              ctlDpr,
  input  logic              ctlIpriom,
  input  logic [PRIO_W-1:0] ctlIprio,
  output vsStrobe_t         strb
);
  logic extValid, injValid, iidIsExt, iprioZero;
  prioKind_e extKind;

  always_comb begin
    iidIsExt  = (ctlIid == ID_W'(EXT_ID));
    iprioZero = (ctlIprio == '0);
    extValid  = extPend & extEn;
    injValid  = !iidIsExt;
    extKind   = (iidIsExt && !iprioZero) ? PK_IPRIO : PK_MAX;

    strb = '{selExt: 1'b0, selInj: 1'b0, selMajor: 1'b0, kind: PK_ONE};
    if (!ctlVti) begin
      if (majorHit) begin
        if (majorIdx == IDX_W'(EXT_ID)) strb.selExt = 1'b1;
        else                            strb.selMajor = 1'b1;
      end
    end else if (extValid && injValid) begin
      if (ctlDpr) strb.selExt = 1'b1;
      else        strb.selInj = 1'b1;
    end else if (extValid) begin
      strb.selExt = 1'b1;
    end else if (injValid) begin
      strb.selInj = 1'b1;
    end

    if (!ctlIpriom)        strb.kind = PK_ONE;
    else if (strb.selExt)  strb.kind = extKind;
    else if (strb.selInj)  strb.kind = !iprioZero ? PK_IPRIO : (ctlDpr ? PK_MAX : PK_ZERO);
    else                   strb.kind = PK_MAX;
  end

  p_one_winner_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.selExt, strb.selInj, strb.selMajor}));
  p_ext_needs_both_r2: assert property (@(posedge clk) disable iff (rst)
    (ctlVti && strb.selExt) |-> (extPend && extEn));
  p_inj_not_ext_r3: assert property (@(posedge clk) disable iff (rst)
    strb.selInj |-> (ctlVti && ctlIid != ID_W'(EXT_ID)));
  p_dpr_order_r4: assert property (@(posedge clk) disable iff (rst)
    (ctlVti && extPend && extEn && ctlIid != ID_W'(EXT_ID)) |-> (ctlDpr ? strb.selExt : strb.selInj));
  p_plain_mode_r1: assert property (@(posedge clk) disable iff (rst)
    !ctlVti |-> (majorHit == (strb.selExt || strb.selMajor)));
endmodule

// File: rtl/vs_top_dp.sv
module vs_top_dp
  import vs_top_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  vsStrobe_t         strb,
  input  logic [IDX_W-1:0]  majorIdx,
  input  logic [ID_W-1:0]   ctlIid,
  input  logic              ctlIpriom,
  input  logic [PRIO_W-1:0] ctlIprio,
  output logic [WORD_W-1:0] topWord,
  output logic              vsPendFlag
);
  logic [ID_W-1:0]   winId;
  logic [PRIO_W-1:0] winPrio;
  logic              anyWin;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    anyWin = strb.selExt | strb.selInj | strb.selMajor;
    if (strb.selExt)      winId = ID_W'(EXT_ID);
    else if (strb.selInj) winId = ctlIid;
    else                  winId = ID_W'(majorIdx);
    unique case (strb.kind)
      PK_ZERO:  winPrio = '0;
      PK_ONE:   winPrio = PRIO_W'(1);
      PK_IPRIO: winPrio = ctlIprio;
      default:  winPrio = '1;
    endcase
    nextWord = '0;
    if (anyWin) begin
      nextWord[ID_LSB +: ID_W] = winId;
      nextWord[PRIO_W-1:0]     = winPrio;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WORD_W-1:0] wordQ;
      always_ff @(posedge clk) begin
        if (rst) wordQ <= '0;
        else     wordQ <= nextWord;
      end
      assign topWord = wordQ;

      p_reg_follow_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (topWord == $past(nextWord)));
    end else begin : g_comb
      assign topWord = nextWord;
    end
  endgenerate

  assign vsPendFlag = (topWord != '0);

  p_const_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctlIpriom && anyWin) |-> (nextWord[PRIO_W-1:0] == PRIO_W'(1)));
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !anyWin |-> (nextWord == '0));
endmodule

// File: rtl/vs_top_intr_select.sv
module vs_top_intr_select
  import vs_top_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] vsPending,
  input  logic [NUM_IRQ-1:0] vsEnable,
  input  logic               ctlVti,
  input  logic [11:0]        ctlIid,
  input  logic               ctlDpr,
  input  logic               ctlIpriom,
  input  logic [7:0]         ctlIprio,
  output logic [31:0]        topWord,
  output logic               vsPendFlag
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] active;
  logic               majorHit;
  logic [IDX_W-1:0]   majorIdx;
  vsStrobe_t          strb;

  assign active = vsPending & vsEnable;

  vs_major_enc #(.NUM_IRQ(NUM_IRQ)) i_enc (
    .active(active), .hit(majorHit), .idx(majorIdx)
  );

  vs_top_ctrl #(.NUM_IRQ(NUM_IRQ)) i_ctrl (
    .clk(clk), .rst(rst),
    .extPend(vsPending[EXT_ID]), .extEn(vsEnable[EXT_ID]),
    .majorHit(majorHit), .majorIdx(majorIdx),
    .ctlVti(ctlVti), .ctlIid(ctlIid), .ctlDpr(ctlDpr),
    .ctlIpriom(ctlIpriom), .ctlIprio(ctlIprio),
    .strb(strb)
  );

  vs_top_dp #(.NUM_IRQ(NUM_IRQ), .REG_OUT(REG_OUT)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .majorIdx(majorIdx),
    .ctlIid(ctlIid), .ctlIpriom(ctlIpriom), .ctlIprio(ctlIprio),
    .topWord(topWord), .vsPendFlag(vsPendFlag)
  );
endmodule

// File: tb/test_vs_top_intr_select.sv
module test_vs_top_intr_select;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NIRQ-1:0] vsPending = '0, vsEnable = '0;
  logic ctlVti = 0, ctlDpr = 0, ctlIpriom = 0;
  logic [11:0] ctlIid = '0;
  logic [7:0] ctlIprio = '0;
  logic [31:0] topWord;
  logic vsPendFlag;

  int errCnt = 0, chkCnt = 0;
  logic [31:0] expPrev = '0;
  string tagPrev = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  vs_top_intr_select #(.NUM_IRQ(NIRQ), .REG_OUT(1'b1)) i_vs_top_intr_select (
    .clk(clk), .rst(rst), .vsPending(vsPending), .vsEnable(vsEnable),
    .ctlVti(ctlVti), .ctlIid(ctlIid), .ctlDpr(ctlDpr),
    .ctlIpriom(ctlIpriom), .ctlIprio(ctlIprio),
    .topWord(topWord), .vsPendFlag(vsPendFlag)
  );

  function automatic logic [31:0] model(input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e,
      input logic vti, input logic [11:0] iid, input logic dpr, input logic pm, input logic [7:0] ip);
    logic [NIRQ-1:0] m = p & e;
    int order[$];
    int id = -1;
    int prio = 0;
    bit winExt = 0, winInj = 0;
    if (!vti) begin
      order = '{9, 1, 5};
      for (int i = 0; i < NIRQ; i++) if (i != 9 && i != 1 && i != 5) order.push_back(i);
      foreach (order[k]) if (id < 0 && m[order[k]]) id = order[k];
      if (id < 0) return 32'h0;
      winExt = (id == 9);
    end else begin
      bit ext = m[9];
      bit inj = (iid != 12'd9);
      if (ext && inj) begin winExt = dpr; winInj = !dpr; end
      else begin winExt = ext; winInj = inj; end
      if (!winExt && !winInj) return 32'h0;
      id = winExt ? 9 : int'(iid);
    end
    if (!pm) prio = 1;
    else if (winExt) prio = (iid == 12'd9 && ip != 0) ? int'(ip) : 255;
    else if (winInj) prio = (ip != 0) ? int'(ip) : (dpr ? 255 : 0);
    else prio = 255;
    return {4'h0, id[11:0], 8'h00, prio[7:0]};
  endfunction

  task automatic check_out(input string tag);
    chkCnt++;
    if (topWord !== expPrev) begin
      errCnt++;
      $display("FAIL %s topWord actual=%h expected=%h", tag, topWord, expPrev);
    end
    chkCnt++;
    if (vsPendFlag !== (expPrev != 0)) begin
      errCnt++;
      $display("FAIL %s vsPendFlag actual=%b expected=%b", tag, vsPendFlag, expPrev != 0);
    end
  endtask

  // Called at a falling edge: check result of previous vector, then apply a new one.
  task automatic step(input string tag, input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e,
      input logic vti, input logic [11:0] iid, input logic dpr, input logic pm, input logic [7:0] ip);
    @(negedge clk);
    check_out(tagPrev);
    vsPending = p; vsEnable = e; ctlVti = vti; ctlIid = iid;
    ctlDpr = dpr; ctlIpriom = pm; ctlIprio = ip;
    expPrev = rst ? 32'h0 : model(p, e, vti, iid, dpr, pm, ip);
    tagPrev = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errCnt++; chkCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    // R10: busy inputs during reset, output must stay zero
    vsPending = '1; vsEnable = '1; ctlIpriom = 1;
    repeat (3) begin
      @(negedge clk);
      check_out("R10");
    end
    @(negedge clk);
    rst = 1'b0;
    // R8: plain pick with constant priority
    vsPending = 16'h0022; vsEnable = 16'h0022; ctlVti = 0; ctlIid = 0;
    ctlDpr = 0; ctlIpriom = 0; ctlIprio = 0;
    expPrev = model(vsPending, vsEnable, 0, 0, 0, 0, 0); tagPrev = "R8";
    step("R1", 16'h0028, 16'hFFFF, 0, 0, 0, 0, 0);           // bit 5 over bit 3
    step("R1", 16'h1008, 16'hFFFF, 0, 0, 0, 0, 0);           // bit 3 over bit 12
    step("R1", 16'h0201, 16'h0201, 0, 0, 0, 0, 0);           // bit 9 over bit 0
    step("R7", 16'h0002, 16'h0002, 0, 12'd0, 0, 1, 8'd44);   // non-ext -> 255
    step("R5", 16'h0200, 16'h0200, 0, 12'd9, 0, 1, 8'd40);   // ext with iprio -> 40
    step("R5", 16'h0200, 16'h0200, 0, 12'd9, 0, 1, 8'd0);    // iprio 0 -> 255
    step("R5", 16'h0200, 16'h0200, 1, 12'd4, 1, 1, 8'd40);   // iid not 9 -> 255
    step("R2", 16'h0200, 16'h0000, 1, 12'd9, 0, 1, 8'd0);    // not enabled -> zero
    step("R2", 16'h0022, 16'h0022, 1, 12'd9, 0, 0, 8'd0);    // other bits ignored
    step("R3", 16'h0200, 16'h0200, 1, 12'd9, 0, 0, 8'd0);    // only ext
    step("R4", 16'h0200, 16'h0200, 1, 12'd3, 0, 0, 8'd0);    // injected wins
    step("R4", 16'h0200, 16'h0200, 1, 12'd3, 1, 0, 8'd0);    // ext wins
    step("R6", 16'h0000, 16'h0000, 1, 12'd3, 0, 1, 8'd0);    // prio 0
    step("R6", 16'h0000, 16'h0000, 1, 12'd3, 1, 1, 8'd0);    // prio 255
    step("R6", 16'h0000, 16'h0000, 1, 12'd3, 0, 1, 8'd77);   // prio 77
    step("R9", 16'h0000, 16'hFFFF, 0, 12'd0, 0, 1, 8'd5);    // nothing -> zero word
    step("R9", 16'h0000, 16'h0000, 1, 12'hABC, 1, 1, 8'd9);  // id field width
    for (int n = 0; n < 400; n++) begin
      logic [11:0] iid = ($urandom % 3 == 0) ? 12'd9 : 12'($urandom);
      step("R9", 16'($urandom), 16'($urandom), 1'($urandom), iid,
           1'($urandom), 1'($urandom), ($urandom % 4 == 0) ? 8'd0 : 8'($urandom));
    end
    @(negedge clk);
    check_out(tagPrev);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule